// File: doc/BRIEF.md
# Preset Up/Down Counter with Boundary Modes

This block is a position-style counter for an already-decoded count stream. Each clock cycle where the count pulse is high and counting is enabled moves the counter one step, up or down as the direction input says. A preset register bounds the count in two of the four boundary modes and is the reload value for load operations. A capture register holds a copy of the count, so the host can read a stable snapshot.

The host programs the block through a small write port with three addresses: configuration, preset and command. An index input is synchronized and edge-detected. Each rising edge either reloads the counter from the preset or captures the counter into the capture register, as a configuration bit selects. Carry and borrow outputs pulse when the count meets its upper or lower boundary.

Top module: `updn_preset_counter`

## Requirements
- R1: After reset the count, the capture register, the preset, carry and borrow are all zero. Counting is disabled and the mode is free-running.
- R2: While the enable bit (configuration bit 2) is clear, count pulses leave the count unchanged.
- R3: Free-running mode (mode code 00) counts through the full range. An up step from all-ones gives zero with carry high, and a down step from zero gives all-ones with borrow high. Each flag is high for exactly the one cycle in which the new count first appears.
- R4: Range-limit mode (code 01) holds the count on an up step when the count is at or above the preset, and on a down step when it is zero. Carry or borrow pulses for each such held step, and a step in the other direction counts normally.
- R5: Non-recycle mode (code 10) wraps like free-running mode, with carry on overflow and borrow on underflow. After such a wrap, further steps are ignored.
- R6: A stopped non-recycle counter counts again only after a clear or a load of the count, whether from a host command or from the index.
- R7: Modulo mode (code 11) turns an up step at or above the preset into zero with carry, and a down step at zero into the preset value with borrow.
- R8: With configuration bit 3 clear, each rising index edge loads the count from the preset. The count changes on the third clock edge after the edge is first sampled. A held-high index acts once only.
- R9: With configuration bit 3 set, each rising index edge copies the count into the capture register, with the same latency, and leaves the count unchanged.
- R10: Host writes are decoded by address. Address 0 sets the mode (bits 1:0), the enable (bit 2) and the index action (bit 3). Address 1 sets the preset. Address 2 issues commands: bit 0 loads the count from the preset, bit 1 captures the count, and bit 2 clears the count. Each command acts on the clock edge that takes the write.
- R11: In one cycle, clear wins over load, and either of them wins over a count step. A capture taken in the same cycle as a step or load records the count from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cntPulse | input | 1 | One step request per high cycle |
| cntUp | input | 1 | Step direction, 1 = up |
| indexIn | input | 1 | Asynchronous index input |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 2 | Host register address |
| hostWdata | input | WIDTH | Host write data |
| cntValue | output | WIDTH | Current count |
| outLatch | output | WIDTH | Captured count |
| carry | output | 1 | Upper boundary pulse |
| borrow | output | 1 | Lower boundary pulse |

## Verification
A capture, from the index or from a host command, can fall in the same clock cycle as a count step. A host load or clear can also coincide with a step. The bench lines up an index edge so that its synchronized rising edge meets a count pulse at the same clock edge. It also issues host commands in the very cycle that a step is requested. It then checks that the capture holds the count from before the step, that load and clear override the step, and that clear overrides load.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'b00,
    MODE_RANGE   = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_MODN    = 2'b11
  } cntMode_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic wrPreset;
    logic clearCntr;
    logic loadCntr;
    logic latchOl;
    logic step;
    logic stepUp;
  } cntStrobe_t;

  localparam logic [1:0] ADDR_CFG    = 2'd0;
  localparam logic [1:0] ADDR_PRESET = 2'd1;
  localparam logic [1:0] ADDR_CMD    = 2'd2;

endpackage

// File: rtl/updn_cnt_ctrl.sv
module updn_cnt_ctrl
  import updn_cnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cntPulse,
  input  logic       cntUp,
  input  logic       indexIn,
  input  logic       hostWe,
  input  logic [1:0] hostAddr,
  input  logic [3:0] hostBits,
  output cntStrobe_t strb,
  output cntMode_e   modeQ,
  output logic       enQ
);

  logic [SYNC_STAGES:0] idxSync;
  logic idxLatchQ;
  logic idxRise;
  logic cmdWr;

  // synchronizer chain plus one extra stage for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) idxSync <= '0;
    else        idxSync <= {idxSync[SYNC_STAGES-1:0], indexIn};
  end

  assign idxRise = idxSync[SYNC_STAGES-1] & ~idxSync[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ     <= MODE_FREE;
      enQ       <= 1'b0;
      idxLatchQ <= 1'b0;
    end else if (hostWe && hostAddr == ADDR_CFG) begin
      modeQ     <= cntMode_e'(hostBits[1:0]);
      enQ       <= hostBits[2];
      idxLatchQ <= hostBits[3];
    end
  end

  assign cmdWr = hostWe && (hostAddr == ADDR_CMD);

  always_comb begin
    strb.wrPreset  = hostWe && (hostAddr == ADDR_PRESET);
    strb.clearCntr = cmdWr & hostBits[2];
    strb.loadCntr  = (cmdWr & hostBits[0]) | (idxRise & ~idxLatchQ);
    strb.latchOl   = (cmdWr & hostBits[1]) | (idxRise & idxLatchQ);
    strb.step      = cntPulse & enQ;
    strb.stepUp    = cntUp;
  end

endmodule

// File: rtl/updn_cnt_datapath.sv
module updn_cnt_datapath
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cntStrobe_t       strb,
  input  cntMode_e         mode,
  input  logic [WIDTH-1:0] presetIn,
  output logic [WIDTH-1:0] cntQ,
  output logic [WIDTH-1:0] olQ,
  output logic [WIDTH-1:0] prQ,
  output logic             carryQ,
  output logic             borrowQ
);

  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [WIDTH-1:0] cntNxt;
  logic cy, bw, haltQ, haltNxt, blocked, atTop, atZero;

  assign atTop   = (cntQ >= prQ);
  assign atZero  = (cntQ == '0);
  assign blocked = (mode == MODE_ONESHOT) && haltQ;

  always_comb begin
    cntNxt  = cntQ;
    cy      = 1'b0;
    bw      = 1'b0;
    haltNxt = haltQ;
    if (strb.clearCntr) begin
      cntNxt  = '0;
      haltNxt = 1'b0;
    end else if (strb.loadCntr) begin
      cntNxt  = prQ;
      haltNxt = 1'b0;
    end else if (strb.step && !blocked) begin
      if (strb.stepUp) begin
        unique case (mode)
          MODE_RANGE: begin
            if (atTop) cy = 1'b1;
            else       cntNxt = cntQ + ONE;
          end
          MODE_MODN: begin
            if (atTop) begin
              cntNxt = '0;
              cy     = 1'b1;
            end else cntNxt = cntQ + ONE;
          end
          default: begin
            cntNxt = cntQ + ONE;
            cy     = (cntQ == ALL_ONES);
            if (mode == MODE_ONESHOT && cntQ == ALL_ONES) haltNxt = 1'b1;
          end
        endcase
      end else begin
        unique case (mode)
          MODE_RANGE: begin
            if (atZero) bw = 1'b1;
            else        cntNxt = cntQ - ONE;
          end
          MODE_MODN: begin
            if (atZero) begin
              cntNxt = prQ;
              bw     = 1'b1;
            end else cntNxt = cntQ - ONE;
          end
          default: begin
            cntNxt = cntQ - ONE;
            bw     = atZero;
            if (mode == MODE_ONESHOT && atZero) haltNxt = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ    <= '0;
      olQ     <= '0;
      prQ     <= '0;
      carryQ  <= 1'b0;
      borrowQ <= 1'b0;
      haltQ   <= 1'b0;
    end else begin
      cntQ    <= cntNxt;
      carryQ  <= cy;
      borrowQ <= bw;
      haltQ   <= haltNxt;
      if (strb.wrPreset) prQ <= presetIn;
      if (strb.latchOl)  olQ <= cntQ;
    end
  end

endmodule

// File: rtl/updn_preset_counter.sv
module updn_preset_counter
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntPulse,
  input  logic             cntUp,
  input  logic             indexIn,
  input  logic             hostWe,
  input  logic [1:0]       hostAddr,
  input  logic [WIDTH-1:0] hostWdata,
  output logic [WIDTH-1:0] cntValue,
  output logic [WIDTH-1:0] outLatch,
  output logic             carry,
  output logic             borrow
);

  cntStrobe_t       strb;
  cntMode_e         modeQ;
  logic             enQ;
  logic [WIDTH-1:0] prValue;

  updn_cnt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cntPulse (cntPulse),
    .cntUp    (cntUp),
    .indexIn  (indexIn),
    .hostWe   (hostWe),
    .hostAddr (hostAddr),
    .hostBits (hostWdata[3:0]),
    .strb     (strb),
    .modeQ    (modeQ),
    .enQ      (enQ)
  );

  updn_cnt_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .mode     (modeQ),
    .presetIn (hostWdata),
    .cntQ     (cntValue),
    .olQ      (outLatch),
    .prQ      (prValue),
    .carryQ   (carry),
    .borrowQ  (borrow)
  );

endmodule

// File: rtl/updn_preset_counter_chk.sv
module updn_preset_counter_chk
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input logic             clk,
  input logic             rst_n,
  input cntStrobe_t       strb,
  input cntMode_e         modeQ,
  input logic             enQ,
  input logic [WIDTH-1:0] prValue,
  input logic [WIDTH-1:0] cntValue,
  input logic [WIDTH-1:0] outLatch,
  input logic             carry,
  input logic             borrow
);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!enQ && !strb.loadCntr && !strb.clearCntr) |=> $stable(cntValue));

  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry && borrow));

  a_r4_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_RANGE && strb.step && strb.stepUp && cntValue >= prValue
     && !strb.loadCntr && !strb.clearCntr) |=> ($stable(cntValue) && carry));

  a_r7_modn_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_MODN && strb.step && strb.stepUp && cntValue >= prValue
     && !strb.loadCntr && !strb.clearCntr) |=> (cntValue == '0 && carry));

  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    strb.latchOl |=> (outLatch == $past(cntValue)));

  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearCntr |=> (cntValue == '0));

  a_r11_load_over_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadCntr && !strb.clearCntr) |=> (cntValue == $past(prValue)));

endmodule

bind updn_preset_counter updn_preset_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strb     (strb),
  .modeQ    (modeQ),
  .enQ      (enQ),
  .prValue  (prValue),
  .cntValue (cntValue),
  .outLatch (outLatch),
  .carry    (carry),
  .borrow   (borrow)
);

// File: tb/updn_preset_counter_bench.sv
`timescale 1ns/1ps
module updn_preset_counter_bench;

  localparam int W   = 4;
  localparam int MAX = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, cntPulse = 1'b0, cntUp = 1'b0, indexIn = 1'b0, hostWe = 1'b0;
  logic [1:0]   hostAddr  = '0;
  logic [W-1:0] hostWdata = '0;
  logic [W-1:0] cntValue, outLatch;
  logic carry, borrow;

  int total = 0;
  int bad   = 0;
  int mCnt, mPr;
  bit mHalt, eCy, eBw;

  always #2.5 clk = ~clk;

  updn_preset_counter #(.WIDTH(W)) u_updn_preset_counter (
    .clk(clk), .rst_n(rst_n), .cntPulse(cntPulse), .cntUp(cntUp), .indexIn(indexIn),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .cntValue(cntValue), .outLatch(outLatch), .carry(carry), .borrow(borrow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic step(input bit up);
    @(negedge clk);
    cntPulse = 1'b1; cntUp = up;
    @(negedge clk);
    cntPulse = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected behaviour from the requirements, applied to mCnt/mPr/mHalt
  task automatic model(input int mode, input bit up);
    eCy = 1'b0; eBw = 1'b0;
    if (mode == 2 && mHalt) return;
    if (up) begin
      if (mode == 1) begin
        if (mCnt >= mPr) eCy = 1'b1; else mCnt++;
      end else if (mode == 3) begin
        if (mCnt >= mPr) begin mCnt = 0; eCy = 1'b1; end else mCnt++;
      end else begin
        if (mCnt == MAX) begin mCnt = 0; eCy = 1'b1; if (mode == 2) mHalt = 1'b1; end
        else mCnt++;
      end
    end else begin
      if (mode == 1) begin
        if (mCnt == 0) eBw = 1'b1; else mCnt--;
      end else if (mode == 3) begin
        if (mCnt == 0) begin mCnt = mPr; eBw = 1'b1; end else mCnt--;
      end else begin
        if (mCnt == 0) begin mCnt = MAX; eBw = 1'b1; if (mode == 2) mHalt = 1'b1; end
        else mCnt--;
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    string tags [4];
    tags[0] = "R3"; tags[1] = "R4"; tags[2] = "R5"; tags[3] = "R7";
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 count", cntValue, 0);
    check("R1 capture", outLatch, 0);
    check("R1 flags", {carry, borrow}, 0);

    // R2 disabled after reset, then disabled again after counting
    step(1); step(1); step(0);
    check("R2 reset-disabled", cntValue, 0);
    hostWrite(2'd0, 4'b0100);
    step(1); step(1);
    check("R2 enabled counts", cntValue, 2);
    hostWrite(2'd0, 4'b0000);
    step(1); step(0); step(1);
    check("R2 disabled ignores", cntValue, 2);

    // sweep every mode and every preset value
    for (int mode = 0; mode < 4; mode++) begin
      for (int pr = 0; pr <= MAX; pr++) begin
        hostWrite(2'd0, W'(4 | mode));
        hostWrite(2'd1, W'(pr));
        hostWrite(2'd2, 4'b0001);
        mCnt = pr; mPr = pr; mHalt = 1'b0;
        for (int i = 0; i < 44; i++) begin
          bit up;
          up = (i < 20) || (i >= 40);
          step(up);
          model(mode, up);
          check(tags[mode], {cntValue, carry, borrow}, {W'(mCnt), eCy, eBw});
        end
      end
    end

    // R6 re-enable after non-recycle stop
    hostWrite(2'd0, 4'b0110);
    hostWrite(2'd1, 4'd5);
    hostWrite(2'd2, 4'b0001);
    repeat (11) step(1);
    check("R6 stopped at wrap", cntValue, 0);
    step(1);
    check("R6 still stopped", cntValue, 0);
    hostWrite(2'd2, 4'b0100);
    step(1);
    check("R6 clear restarts", cntValue, 1);
    step(0); step(0);
    check("R6 underflow", cntValue, MAX);
    step(0);
    check("R6 held after underflow", cntValue, MAX);
    hostWrite(2'd2, 4'b0001);
    step(0);
    check("R6 load restarts", cntValue, 4);

    // R10 host commands
    hostWrite(2'd2, 4'b0010);
    check("R10 capture", outLatch, 4);
    hostWrite(2'd2, 4'b0100);
    check("R10 clear", cntValue, 0);
    hostWrite(2'd2, 4'b0001);
    check("R10 load", cntValue, 5);

    // R8 index reloads count
    hostWrite(2'd0, 4'b0100);
    hostWrite(2'd1, 4'd9);
    hostWrite(2'd2, 4'b0100);
    @(negedge clk) indexIn = 1'b1;
    waitCycles(2);
    check("R8 not yet", cntValue, 0);
    waitCycles(1);
    check("R8 index load", cntValue, 9);
    hostWrite(2'd2, 4'b0100);
    waitCycles(4);
    check("R8 acts once", cntValue, 0);
    @(negedge clk) indexIn = 1'b0;
    waitCycles(4);

    // R9 index captures count
    hostWrite(2'd0, 4'b1100);
    step(1); step(1);
    @(negedge clk) indexIn = 1'b1;
    waitCycles(4);
    check("R9 capture", outLatch, 2);
    check("R9 count kept", cntValue, 2);
    @(negedge clk) indexIn = 1'b0;
    waitCycles(4);

    // R11 index capture coinciding with a step
    step(1); step(1); step(1);
    @(negedge clk) indexIn = 1'b1;
    @(negedge clk);
    @(negedge clk) begin cntPulse = 1'b1; cntUp = 1'b1; end
    @(negedge clk) cntPulse = 1'b0;
    check("R11 capture pre-step", outLatch, 5);
    check("R11 step applied", cntValue, 6);
    @(negedge clk) indexIn = 1'b0;
    waitCycles(4);

    // R11 host load with a step
    @(negedge clk) begin hostWe = 1'b1; hostAddr = 2'd2; hostWdata = 4'b0001; cntPulse = 1'b1; cntUp = 1'b1; end
    @(negedge clk) begin hostWe = 1'b0; cntPulse = 1'b0; end
    check("R11 load beats step", {cntValue, carry}, {4'd9, 1'b0});

    // R11 clear with load and a step
    @(negedge clk) begin hostWe = 1'b1; hostAddr = 2'd2; hostWdata = 4'b0101; cntPulse = 1'b1; cntUp = 1'b0; end
    @(negedge clk) begin hostWe = 1'b0; cntPulse = 1'b0; end
    check("R11 clear beats load", cntValue, 0);

    // R11 host capture with a step
    @(negedge clk) begin hostWe = 1'b1; hostAddr = 2'd2; hostWdata = 4'b0010; cntPulse = 1'b1; cntUp = 1'b1; end
    @(negedge clk) begin hostWe = 1'b0; cntPulse = 1'b0; end
    check("R11 host capture pre-step", outLatch, 0);
    check("R11 host capture step", cntValue, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule